// File: doc/BRIEF.md
# Data-Jitter Stress Sample Generator

This block produces a repeating stream of 24-bit two's-complement audio samples chosen to provoke the worst data-dependent jitter in a serial audio link. It is driven by a sample strobe. Each strobe emits the next word of a fixed 192-word cycle, and the same word goes to the left and right channels.

The cycle is built from two components. The first is a fast square wave with a period of four samples, a quarter of the sample rate. The second is a slow alternation that subtracts one from every word in the second half of the cycle. That subtraction flips the 22 low bits together, so the density of ones in the transmitted data swings at the cycle rate. At 48 kHz this gives a 12 kHz tone and a 250 Hz alternation.

A silence input replaces the output with zero, for baseline comparison runs. The position counters keep advancing during silence, so the pattern comes back in phase when silence is released. Framing and line coding belong to a downstream serialiser.

Top module: `jtest_gen`

## Requirements
- R1: While synchronous reset `rst` is high, and on the cycle after it is released, `valid_o` is 0 and both sample outputs are zero. The first strobe after reset emits 24'hC00000.
- R2: The sample outputs change only on the clock cycle after a cycle with `strobe_i` high. `valid_o` is high for exactly the cycles that follow a strobe cycle. Without a strobe, the outputs hold their value.
- R3: In the first half of the cycle (positions 0 to 95), position p emits 24'hC00000 when p mod 4 is 0 or 1, and 24'h400000 when p mod 4 is 2 or 3.
- R4: In the second half of the cycle (positions 96 to 191), position p emits 24'hBFFFFF when p mod 4 is 0 or 1, and 24'h3FFFFF when p mod 4 is 2 or 3. Each such word equals the first-half word at the same place minus one.
- R5: Every emitted non-silent word has its 22 low bits either all zero or all one.
- R6: The cycle is 192 strobes long. Position 96 starts the second half, and the 193rd strobe emits position 0 again.
- R7: `left_o` and `right_o` always carry the same value.
- R8: A strobe taken while `silence_i` is high emits zero with `valid_o` high. The position still advances, so the first strobe after silence emits the word for its true position.
- R9: A reset in the middle of a cycle returns the generator to position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Advance to the next sample |
| silence_i | input | 1 | Emit zero in place of the pattern word |
| valid_o | output | 1 | High on the cycle after a strobe |
| left_o | output | 24 | Left channel sample |
| right_o | output | 24 | Right channel sample |

## Verification
The bench targets the seams of the cycle:
- **Quarter-period step (positions 3 to 4).** A phase counter that wraps at the wrong count would shift the square wave.
- **Half-cycle edge (positions 95 to 96).** A group counter that stops one group early or late would move the flip of the low bits away from position 96.
- **Wrap at position 192.** An off-by-one here would lengthen or shorten the cycle, and the bench would see a wrong word.

It also runs silence across a known stretch of strobes. A design that froze its counters during silence would then resume on the wrong word. Further checks cover held outputs between strobes, back-to-back strobes, and a reset taken mid-cycle.

// File: rtl/jtest_gen.sv
module jtest_gen #(
  parameter int W      = 24,
  parameter int GROUPS = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe_i,
  input  logic         silence_i,
  output logic         valid_o,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o
);
  localparam int GW = $clog2(GROUPS);
  localparam logic [W-1:0] HI_WORD = {2'b11, {(W-2){1'b0}}};
  localparam logic [W-1:0] LO_WORD = {2'b01, {(W-2){1'b0}}};

  logic [1:0]    phase_q;
  logic [GW-1:0] group_q;
  logic          half_q;
  logic          valid_q;
  logic [W-1:0]  sample_q;

  wire           last_group = (group_q == GW'(GROUPS - 1));
  wire [W-1:0]   base_word  = phase_q[1] ? LO_WORD : HI_WORD;
  wire [W-1:0]   pat_word   = base_word - {{(W-1){1'b0}}, half_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      group_q  <= '0;
      half_q   <= 1'b0;
      valid_q  <= 1'b0;
      sample_q <= '0;
    end else begin
      valid_q <= strobe_i;
      if (strobe_i) begin
        sample_q <= silence_i ? '0 : pat_word;
        phase_q  <= phase_q + 2'd1;
        if (phase_q == 2'd3) begin
          if (last_group) begin
            group_q <= '0;
            half_q  <= ~half_q;
          end else begin
            group_q <= group_q + GW'(1);
          end
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign left_o  = sample_q;
  assign right_o = sample_q;
endmodule

// File: rtl/jtest_gen_chk.sv
module jtest_gen_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic         strobe_i,
  input logic         silence_i,
  input logic         valid_o,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!valid_o && left_o == '0)); // R1

  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    strobe_i |=> valid_o); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> (!valid_o && $stable(left_o))); // R2

  AST_LOW_BITS_UNISON: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (left_o[W-3:0] == '0 || left_o[W-3:0] == '1)); // R5

  AST_CHANNELS_MATCH: assert property (@(posedge clk) disable iff (rst)
    left_o == right_o); // R7

  AST_SILENCE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (strobe_i && silence_i) |=> (valid_o && left_o == '0)); // R8
endmodule

bind jtest_gen jtest_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .strobe_i(strobe_i), .silence_i(silence_i),
  .valid_o(valid_o), .left_o(left_o), .right_o(right_o)
);

// File: tb/jtest_gen_tb_top.sv
module jtest_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe_i = 1'b0;
  logic        silence_i = 1'b0;
  logic        valid_o;
  logic [23:0] left_o, right_o;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  int          pos;

  always #5 clk = ~clk;

  jtest_gen dut_i (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .silence_i(silence_i),
    .valid_o(valid_o), .left_o(left_o), .right_o(right_o)
  );

  typedef struct packed { logic [7:0] idx; logic [23:0] val; } vec_t;
  localparam vec_t VECS [12] = '{
    '{8'd0,   24'hC00000}, '{8'd1,   24'hC00000}, '{8'd2,   24'h400000},
    '{8'd3,   24'h400000}, '{8'd4,   24'hC00000}, '{8'd95,  24'h400000},
    '{8'd96,  24'hBFFFFF}, '{8'd97,  24'hBFFFFF}, '{8'd98,  24'h3FFFFF},
    '{8'd99,  24'h3FFFFF}, '{8'd191, 24'h3FFFFF}, '{8'd192, 24'hC00000}
  };

  function automatic logic [23:0] model(int p);
    logic [23:0] w;
    w = ((p % 4) < 2) ? 24'hC00000 : 24'h400000;
    if ((p % 192) >= 96) w = w - 24'd1;
    return w;
  endfunction

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) strobe_i = 1'b1;
    @(negedge clk) strobe_i = 1'b0;
    pos++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    pos = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {23'd0, valid_o}, 24'd0);
    chk("R1 sample in reset", left_o, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", {23'd0, valid_o}, 24'd0);

    // R3 R4 R6: table walk
    foreach (VECS[i]) begin
      while (pos < int'(VECS[i].idx)) pulse();
      pulse();
      chk("R3/R4/R6 table word", left_o, VECS[i].val);
      chk("R2 valid after strobe", {23'd0, valid_o}, 24'd1);
      chk("R7 right channel", right_o, left_o);
    end

    // R2: idle holds
    @(negedge clk);
    chk("R2 valid idle", {23'd0, valid_o}, 24'd0);
    repeat (5) @(negedge clk);
    chk("R2 hold without strobe", left_o, model(pos - 1));

    // R2: back-to-back strobes
    @(negedge clk) strobe_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R2 back-to-back", left_o, model(pos));
      chk("R2 valid back-to-back", {23'd0, valid_o}, 24'd1);
      pos++;
    end
    strobe_i = 1'b0;

    // R8: silence across the half-cycle edge
    while ((pos % 192) != 93) pulse();
    silence_i = 1'b1;
    for (int k = 0; k < 5; k++) begin
      pulse();
      chk("R8 silent word", left_o, 24'd0);
      chk("R8 silent valid", {23'd0, valid_o}, 24'd1);
    end
    silence_i = 1'b0;
    pulse();
    chk("R8 resume in phase", left_o, model(pos - 1));
    chk("R7 right after resume", right_o, model(pos - 1));

    // R9: reset mid-cycle
    repeat (7) pulse();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R9 sample cleared", left_o, 24'd0);
    pos = 0;
    pulse();
    chk("R9 restart word 0", left_o, 24'hC00000);
    pulse(); pulse();
    chk("R9 restart word 2", left_o, 24'h400000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule